// File: doc/BRIEF.md
# Narrow-Access Register Bridge with Write Spacing

The bridge connects a host that issues 8-, 16- and 32-bit register reads and writes to a peripheral register file that accepts only aligned 32-bit accesses. Every downstream access goes to the word address, which is the request address with its two low bits forced to zero. A narrow read fetches the full word and returns only the addressed lane, zero-extended. A narrow write fetches the word, replaces only the addressed lane, and writes the merged word back.

One word of the register file holds a pair of 16-bit registers that the peripheral must receive together. The low half is the mode half and the high half is the trigger half. A halfword write to the mode half is not forwarded. The bridge merges it into a current copy of the word and keeps the result in a holding register. A later halfword write to the trigger half uses that holding register as its old word instead of reading the peripheral, and sends both halves in one downstream write.

The peripheral can drop a write that arrives too soon after the previous one. The bridge therefore keeps downstream write strobes at least `GAP_US` microseconds apart, using a counter that advances once every `TICK_DIV` clocks. Reads never wait for this counter.

The host side uses a valid/ready handshake with one request outstanding at a time. The size code is 0 for a byte, 1 for a halfword, and 2 or 3 for a word. Write data and read data sit in the low bits of their buses. The peripheral returns read data combinationally, in the same cycle as the read strobe.

Top module: `narrow_reg_bridge`

## Requirements
- R1: Every downstream read or write strobe carries an address whose two low bits are zero.
- R2: A byte read (size 0) returns bits [8*a+7:8*a] of the addressed word in h_rdata[7:0], with zeros above, where a is address bits [1:0].
- R3: A halfword read (size 1) returns bits [16*h+15:16*h] of the word in h_rdata[15:0], with zeros above, where h is address bit 1.
- R4: A byte write performs one downstream read and one downstream write, and changes only the addressed byte lane to h_wdata[7:0].
- R5: A halfword write outside the paired word changes only the addressed 16-bit lane to h_wdata[15:0], again with one read and one write.
- R6: A word write (size 2 or 3) performs no downstream read, and exactly one write of h_wdata.
- R7: A halfword write to the mode half (address XFER_ADDR, default 0x0C) produces no downstream write. It stores the fetched word, with its low half replaced, in the holding register, so a later word read of that address returns the unchanged peripheral value.
- R8: A halfword write to the trigger half (address XFER_ADDR+2) performs no downstream read. It performs exactly one write of {h_wdata[15:0], holding register[15:0]}.
- R9: Two downstream write strobes are at least GAP_US*TICK_DIV clock cycles apart.
- R10: A read gets its response exactly two cycles after acceptance, even while the write spacing counter is running.
- R11: h_ready is low from the cycle after acceptance until the response has been given. h_rvalid is a one-cycle pulse, and h_ready is high again in the cycle after it.
- R12: The holding register is zero after reset. A trigger-half write with no earlier mode-half write sends zero in the low half.
- R13: During reset, h_ready is high and h_rvalid, d_rd and d_wr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Bridge can accept a request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| h_addr | input | ADDR_W | Byte address of the request |
| h_wdata | input | 32 | Write data, low-aligned |
| h_rvalid | output | 1 | Response pulse (read data valid, or write done) |
| h_rdata | output | 32 | Read data, low-aligned and zero-extended |
| d_rd | output | 1 | Downstream read strobe |
| d_wr | output | 1 | Downstream write strobe |
| d_addr | output | ADDR_W | Downstream word-aligned address |
| d_wdata | output | 32 | Downstream write word |
| d_rdata | input | 32 | Downstream read word, valid while d_rd is high |

## Verification
The assertions assume the peripheral presents d_rdata in the same cycle as d_rd. They also assume a host that holds a request stable until h_ready accepts it and never issues a second request before the response. The bench holds h_valid and its fields constant from one falling edge until the accepting edge, and drops them at the next falling edge. Halfword requests always use even addresses. The bench's peripheral model answers reads combinationally from its own word array and updates that array only on d_wr.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT_GAP,
    ST_WRITE,
    ST_RESP
  } brg_state_t;

  // Bit offset of the addressed lane inside the word.
  function automatic logic [4:0] lane_shift(input logic [1:0] sz, input logic [1:0] lane);
    case (sz)
      SZ_BYTE: return {lane, 3'b000};
      SZ_HALF: return {lane[1], 4'b0000};
      default: return 5'd0;
    endcase
  endfunction

  // Unshifted mask of the lane width.
  function automatic logic [WORD_W-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return WORD_W'(32'h0000_00FF);
      SZ_HALF: return WORD_W'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] lane_extract(input logic [WORD_W-1:0] w,
                                                     input logic [1:0] sz,
                                                     input logic [1:0] lane);
    return (w >> lane_shift(sz, lane)) & lane_mask(sz);
  endfunction

  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old,
                                                   input logic [WORD_W-1:0] wd,
                                                   input logic [1:0] sz,
                                                   input logic [1:0] lane);
    logic [WORD_W-1:0] m;
    m = lane_mask(sz) << lane_shift(sz, lane);
    return (old & ~m) | ((wd & lane_mask(sz)) << lane_shift(sz, lane));
  endfunction
endpackage

// File: rtl/req_decode.sv
module req_decode import bridge_pkg::*; #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned XFER_ADDR = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              is_word,
  output logic              is_mode_hw,
  output logic              is_trig_hw
);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(XFER_ADDR);
  localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(XFER_ADDR + 2);

  assign is_word    = size[1];
  assign is_mode_hw = (size == SZ_HALF) && (addr[ADDR_W-1:1] == MODE_A[ADDR_W-1:1]);
  assign is_trig_hw = (size == SZ_HALF) && (addr[ADDR_W-1:1] == TRIG_A[ADDR_W-1:1]);
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int unsigned TICK_DIV = 50,
  parameter int unsigned GAP_US   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_fire,
  output logic gap_busy
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned US_W  = $clog2(GAP_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [US_W-1:0]  US_LOAD  = US_W'(GAP_US);

  logic [PRE_W-1:0] pre_cnt;
  logic [US_W-1:0]  us_left;
  logic             us_tick;

  assign us_tick  = (pre_cnt == PRE_LAST);
  assign gap_busy = (us_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      us_left <= '0;
    end else if (wr_fire) begin
      pre_cnt <= '0;
      us_left <= US_LOAD;
    end else if (gap_busy) begin
      if (us_tick) begin
        pre_cnt <= '0;
        us_left <= us_left - 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end

  // R9: the prescaler never runs past its last count
  p_prescale_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= PRE_LAST);

  // R9: the counter only falls while no new write is reloading it
  p_us_monotone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_busy && !wr_fire && !us_tick) |=> $stable(us_left));
endmodule

// File: rtl/narrow_reg_bridge.sv
module narrow_reg_bridge import bridge_pkg::*; #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned TICK_DIV  = 50,
  parameter int unsigned GAP_US    = 6,
  parameter int unsigned XFER_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic [1:0]        h_size,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [WORD_W-1:0] h_wdata,
  output logic              h_rvalid,
  output logic [WORD_W-1:0] h_rdata,
  output logic              d_rd,
  output logic              d_wr,
  output logic [ADDR_W-1:0] d_addr,
  output logic [WORD_W-1:0] d_wdata,
  input  logic [WORD_W-1:0] d_rdata
);
  localparam int unsigned GAP_CYC = GAP_US * TICK_DIV;
  localparam int unsigned SINCE_W = $clog2(GAP_CYC + 1) + 1;
  localparam logic [SINCE_W-1:0] GAP_LIM = SINCE_W'(GAP_CYC);

  brg_state_t        state;
  logic              r_we;
  logic [1:0]        r_size;
  logic [ADDR_W-1:0] r_addr;
  logic [WORD_W-1:0] r_wdata;
  logic [WORD_W-1:0] r_merge;
  logic [WORD_W-1:0] r_rdata;
  logic [WORD_W-1:0] shadow;
  logic              r_mode_hw;

  logic accept;
  logic in_word, in_mode_hw, in_trig_hw;
  logic gap_busy;
  logic [WORD_W-1:0] fetched_merge;

  req_decode #(.ADDR_W(ADDR_W), .XFER_ADDR(XFER_ADDR)) u_dec (
    .addr       (h_addr),
    .size       (h_size),
    .is_word    (in_word),
    .is_mode_hw (in_mode_hw),
    .is_trig_hw (in_trig_hw)
  );

  gap_timer #(.TICK_DIV(TICK_DIV), .GAP_US(GAP_US)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (d_wr),
    .gap_busy (gap_busy)
  );

  assign accept        = h_valid && h_ready;
  assign fetched_merge = lane_merge(d_rdata, r_wdata, r_size, r_addr[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_we      <= 1'b0;
      r_size    <= '0;
      r_addr    <= '0;
      r_wdata   <= '0;
      r_merge   <= '0;
      r_rdata   <= '0;
      shadow    <= '0;
      r_mode_hw <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          r_we      <= h_write;
          r_size    <= h_size;
          r_addr    <= h_addr;
          r_wdata   <= h_wdata;
          r_mode_hw <= in_mode_hw;
          if (!h_write) begin
            state <= ST_READ;
          end else if (in_word) begin
            r_merge <= h_wdata;
            state   <= ST_WAIT_GAP;
          end else if (in_trig_hw) begin
            r_merge <= lane_merge(shadow, h_wdata, h_size, h_addr[1:0]);
            state   <= ST_WAIT_GAP;
          end else begin
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (!r_we) begin
            r_rdata <= lane_extract(d_rdata, r_size, r_addr[1:0]);
            state   <= ST_RESP;
          end else if (r_mode_hw) begin
            shadow <= fetched_merge;
            state  <= ST_RESP;
          end else begin
            r_merge <= fetched_merge;
            state   <= ST_WAIT_GAP;
          end
        end
        ST_WAIT_GAP: if (!gap_busy) state <= ST_WRITE;
        ST_WRITE:    state <= ST_RESP;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  assign h_ready  = (state == ST_IDLE);
  assign h_rvalid = (state == ST_RESP);
  assign h_rdata  = r_rdata;
  assign d_rd     = (state == ST_READ);
  assign d_wr     = (state == ST_WRITE);
  assign d_addr   = {r_addr[ADDR_W-1:2], 2'b00};
  assign d_wdata  = r_merge;

  // Cycles since the last downstream write, saturating; observes d_wr only.
  logic [SINCE_W-1:0] since_wr;
  always_ff @(posedge clk) begin
    if (!rst_n)                 since_wr <= GAP_LIM;
    else if (d_wr)              since_wr <= SINCE_W'(1);
    else if (since_wr < GAP_LIM) since_wr <= since_wr + 1'b1;
  end

  p_aligned_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd || d_wr) |-> (d_addr[1:0] == 2'b00));

  p_word_write_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && h_write && in_word) |=> !d_rd);

  p_mode_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd && r_we && r_mode_hw) |=> (!d_wr && h_rvalid));

  p_trig_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && h_write && in_trig_hw) |=> !d_rd);

  p_write_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr |-> (since_wr >= GAP_LIM));

  p_read_no_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rd && !r_we) |=> h_rvalid);

  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !h_ready);

  p_resp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    h_rvalid |=> (!h_rvalid && h_ready));
endmodule

// File: tb/sim_narrow_reg_bridge.sv
module sim_narrow_reg_bridge;
  localparam int MINGAP = 6 * 50;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        h_valid, h_write;
  logic [1:0]  h_size;
  logic [7:0]  h_addr;
  logic [31:0] h_wdata;
  logic        h_ready, h_rvalid;
  logic [31:0] h_rdata;
  logic        d_rd, d_wr;
  logic [7:0]  d_addr;
  logic [31:0] d_wdata, d_rdata;

  narrow_reg_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_size(h_size),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
    .d_rd(d_rd), .d_wr(d_wr), .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata)
  );

  int checks = 0, errors = 0, cyc = 0, last_wr = -100000;
  int n_rd = 0, n_wr = 0;
  logic [31:0] periph [64];
  logic [31:0] exp_mem [64];
  logic [31:0] shadow_m;

  function automatic logic [31:0] seed_word(input int i);
    return 32'h3C00_0000 + (i * 32'h0001_0203) ^ 32'h0000_5A5A;
  endfunction

  assign d_rdata = periph[d_addr[7:2]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Peripheral model and per-clock monitor (R1, R9).
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) periph[i] <= seed_word(i);
    end else begin
      if (d_rd || d_wr) begin
        checks++;
        if (d_addr[1:0] != 2'b00) begin
          errors++;
          $display("FAIL R1 actual=%h expected=low bits 00", d_addr);
        end
      end
      if (d_rd) n_rd++;
      if (d_wr) begin
        n_wr++;
        checks++;
        if (cyc - last_wr < MINGAP) begin
          errors++;
          $display("FAIL R9 actual=%0d expected>=%0d", cyc - last_wr, MINGAP);
        end
        last_wr = cyc;
        periph[d_addr[7:2]] <= d_wdata;
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] ref_read(input logic [31:0] w, input logic [1:0] sz, input logic [7:0] a);
    logic [31:0] r = '0;
    if (sz == 2'd0) r[7:0] = w[a[1:0]*8 +: 8];
    else if (sz == 2'd1) r[15:0] = w[a[1]*16 +: 16];
    else r = w;
    return r;
  endfunction

  function automatic logic [31:0] ref_write(input logic [31:0] old, input logic [31:0] wd,
                                            input logic [1:0] sz, input logic [7:0] a);
    logic [31:0] r = old;
    if (sz == 2'd0) r[a[1:0]*8 +: 8] = wd[7:0];
    else if (sz == 2'd1) r[a[1]*16 +: 16] = wd[15:0];
    else r = wd;
    return r;
  endfunction

  logic [31:0] got;
  int          lat;

  task automatic xfer(input bit we, input logic [1:0] sz, input logic [7:0] a, input logic [31:0] wd);
    n_rd = 0; n_wr = 0;
    h_valid = 1'b1; h_write = we; h_size = sz; h_addr = a; h_wdata = wd;
    while (!h_ready) @(negedge clk);
    @(negedge clk);
    h_valid = 1'b0;
    lat = 1;
    while (!h_rvalid) begin @(negedge clk); lat++; end
    got = h_rdata;
    @(negedge clk);
    chk("R11 pulse", {31'b0, h_rvalid}, 32'd0);
    chk("R11 ready", {31'b0, h_ready}, 32'd1);
    if (we) begin
      if (sz == 2'd1 && a[7:1] == 7'h06) shadow_m = ref_write(exp_mem[3], wd, sz, a);
      else if (sz == 2'd1 && a[7:1] == 7'h07) exp_mem[3] = ref_write(shadow_m, wd, sz, a);
      else exp_mem[a[7:2]] = ref_write(exp_mem[a[7:2]], wd, sz, a);
    end
  endtask

  task automatic rd(input string tag, input logic [1:0] sz, input logic [7:0] a);
    xfer(1'b0, sz, a, 32'h0);
    chk(tag, got, ref_read(exp_mem[a[7:2]], sz, a));
    chk("R10 latency", lat, 2);
  endtask

  initial begin
    rst_n = 1'b0; h_valid = 1'b0; h_write = 1'b0; h_size = 2'd0; h_addr = '0; h_wdata = '0;
    shadow_m = '0;
    for (int i = 0; i < 64; i++) exp_mem[i] = seed_word(i);
    repeat (3) @(negedge clk);
    chk("R13 ready", {31'b0, h_ready}, 32'd1);
    chk("R13 rvalid", {31'b0, h_rvalid}, 32'd0);
    chk("R13 strobes", {30'b0, d_rd, d_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 / R8: trigger half first, holding register still zero
    xfer(1'b1, 2'd1, 8'h0E, 32'h0000_1234);
    chk("R8 no read", n_rd, 0);
    chk("R8 one write", n_wr, 1);
    rd("R12 low half zero", 2'd2, 8'h0C);
    chk("R12 word", got, 32'h1234_0000);

    // R2 byte lanes, R3 halfword lanes
    for (int k = 0; k < 4; k++) rd("R2 byte lane", 2'd0, 8'h10 + 8'(k));
    rd("R3 half lane0", 2'd1, 8'h14);
    rd("R3 half lane1", 2'd1, 8'h16);

    // R4 byte writes, back to back (R9 gap watched by monitor)
    xfer(1'b1, 2'd0, 8'h21, 32'hFFFF_FFC3);
    chk("R4 reads", n_rd, 1);
    chk("R4 writes", n_wr, 1);
    rd("R4 word after byte write", 2'd2, 8'h20);
    xfer(1'b1, 2'd0, 8'h23, 32'h0000_007E);
    xfer(1'b1, 2'd0, 8'h20, 32'h0000_0011);
    rd("R4 word after two more", 2'd2, 8'h20);

    // R5 halfword write
    xfer(1'b1, 2'd1, 8'h32, 32'h5555_ABCD);
    chk("R5 reads", n_rd, 1);
    chk("R5 writes", n_wr, 1);
    rd("R5 word", 2'd2, 8'h30);

    // R6 word writes, size 2 and 3
    xfer(1'b1, 2'd2, 8'h40, 32'hDEAD_BEEF);
    chk("R6 no read", n_rd, 0);
    chk("R6 one write", n_wr, 1);
    xfer(1'b1, 2'd3, 8'h45, 32'h0BAD_F00D);
    chk("R6 size3 no read", n_rd, 0);
    rd("R6 word 40", 2'd2, 8'h40);
    rd("R6 word 44", 2'd2, 8'h44);

    // R7 mode half held back
    xfer(1'b1, 2'd1, 8'h0C, 32'h0000_BEEF);
    chk("R7 no write", n_wr, 0);
    rd("R7 peripheral unchanged", 2'd2, 8'h0C);
    chk("R7 word", got, 32'h1234_0000);

    // R8 trigger half merges the held half
    xfer(1'b1, 2'd1, 8'h0E, 32'h0000_0055);
    chk("R8 no read", n_rd, 0);
    chk("R8 one write", n_wr, 1);
    rd("R8 merged word", 2'd2, 8'h0C);
    chk("R8 word", got, 32'h0055_BEEF);
    rd("R3 trigger half", 2'd1, 8'h0E);

    // final sweep of the whole register file
    for (int i = 0; i < 64; i++) rd("R4 sweep", 2'd2, 8'(i * 4));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule